// File: doc/BRIEF.md
# Buffered Compare-Match Interval Timer

This block holds a parameterised number of independent interval-timer channels (four by default). Each channel has a 16-bit up-counter and a 16-bit compare value. While a channel is enabled and its count strobe is high, the counter advances by one per clock. When the count equals the active compare value on a strobed cycle, the counter restarts from zero and the channel raises a one-cycle interrupt pulse. The time between interrupts is therefore the compare value plus one strobed cycles.

The compare value is double-buffered. A host write over a small 16-bit register port lands in a front (master) register. A per-channel transfer state machine moves the master value into the back (slave) register, and only the slave register feeds the comparator. The state machine has two states, IDLE and XFER. An accepted write moves IDLE→XFER and loads a countdown of four clocks. XFER counts down, and on its last clock it copies master to slave and returns XFER→IDLE. If another write is accepted on that same last clock, it stays XFER→XFER with the countdown reloaded. A write that arrives earlier than that last clock is dropped and sets a sticky collision flag. Reads return the master value. A compare value written below the current count only matches after the counter wraps. Each wrap without a match produces a one-cycle overflow pulse.

A low channel-enable bit holds that channel's counter, registers, flags and state machine in asynchronous reset.

Top module: `cmt_timer`

## Requirements
- R1: While a channel's enable bit is 0, its counter, master, slave, collision flag, transfer state, interrupt and overflow outputs are held at zero, and host writes to it have no effect. After reset every compare register and status register reads 0.
- R2: The counter advances by one on each clock where the channel is enabled and its tick input is 1, and holds its value when tick is 0.
- R3: On a clock where tick is 1 and the count equals the slave compare value, the counter returns to 0 and the irq bit is 1 for the following cycle only. With a steady tick, interrupts repeat every compare+1 cycles.
- R4: A write to the compare register (address bit 0 = 0, channel in the upper address bits) loads the master register. A read at that address returns the master value from the next cycle on.
- R5: The slave register takes the master value on the fourth clock edge after the write edge. Until then, matching uses the previous slave value. Status bit 1 reads 1 from the write until that fourth edge.
- R6: A compare write that comes less than four clocks after the last accepted write to the same channel is ignored and sets status bit 0. A status write (address bit 0 = 1) with data bit 0 = 1 clears that bit. A write exactly four clocks after the previous one is accepted.
- R7: A strobed cycle at count FFFFH with no match wraps the counter to 0 and pulses ovf for one cycle. A match at FFFFH produces an interrupt and no overflow. irq and ovf are never high together.
- R8: A compare value written below the current count matches only after the counter wraps through 0000H.
- R9: Channels operate independently: their counts, compare values and flags do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for all channels |
| ch_en | input | N_CH | Per-channel enable; 0 holds that channel in reset |
| tick | input | N_CH | Per-channel count strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | CHW+1 | Bit 0 selects register (0 compare, 1 status); upper bits select the channel |
| bus_wdata | input | W | Host write data |
| bus_rdata | output | W | Combinational read data for the addressed register |
| irq | output | N_CH | One-cycle compare-match pulses |
| ovf | output | N_CH | One-cycle wrap-without-match pulses |

## Verification
The embedded properties check, on every cycle, the cycle-level rules. The slave register changes only at the end of a transfer countdown. A write during the countdown sets the collision flag and leaves the master register unchanged. An accepted write loads the master. The count holds without a tick. An interrupt coincides with a zero count. An overflow follows FFFFH and never coincides with an interrupt. Only the directed scenarios can show the end-to-end timing. These cover the exact cycle on which a new compare value starts governing matches, the interrupt period against a tick pattern, the full wrap path of a lowered compare value, behaviour while a channel is disabled, and the independence of channels running side by side.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Master-to-slave transfer sequencer states
    typedef enum logic [0:0] {
        SH_IDLE = 1'b0,
        SH_XFER = 1'b1
    } sh_state_e;

    // Status register bit positions
    localparam int unsigned ST_COLL_BIT = 0;
    localparam int unsigned ST_PEND_BIT = 1;
    localparam int unsigned ST_W        = 2;

endpackage

// File: rtl/cmt_shadow.sv
module cmt_shadow
    import cmt_pkg::*;
#(
    parameter int unsigned W        = 16,
    parameter int unsigned XFER_CYC = 4
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         clr_coll,
    output logic [W-1:0] master,
    output logic [W-1:0] slave,
    output logic         pending,
    output logic         collision
);

    localparam int unsigned XW = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
    localparam logic [XW-1:0] XLOAD = XW'(XFER_CYC - 1);

    sh_state_e   state_q, state_n;
    logic [XW-1:0] xcnt_q, xcnt_n;
    logic        busy;
    logic        accept;
    logic        load_slave;

    assign busy   = (state_q == SH_XFER) && (xcnt_q != '0);
    assign accept = wr_en && !busy;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= SH_IDLE;
            xcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            xcnt_q  <= xcnt_n;
        end
    end

    // Next state and transfer decision
    always_comb begin
        state_n    = state_q;
        xcnt_n     = xcnt_q;
        load_slave = 1'b0;
        unique case (state_q)
            SH_IDLE: begin
                if (accept) begin
                    state_n = SH_XFER;
                    xcnt_n  = XLOAD;
                end
            end
            SH_XFER: begin
                if (xcnt_q == '0) begin
                    load_slave = 1'b1;
                    if (accept) begin
                        xcnt_n = XLOAD;
                    end else begin
                        state_n = SH_IDLE;
                    end
                end else begin
                    xcnt_n = xcnt_q - XW'(1);
                end
            end
            default: state_n = SH_IDLE;
        endcase
    end

    // Data registers and sticky flag
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            master    <= '0;
            slave     <= '0;
            collision <= 1'b0;
        end else begin
            if (accept) begin
                master <= wr_data;
            end
            if (load_slave) begin
                slave <= master;
            end
            if (wr_en && busy) begin
                collision <= 1'b1;
            end else if (clr_coll) begin
                collision <= 1'b0;
            end
        end
    end

    assign pending = (state_q == SH_XFER);

    // Slave only moves at the end of a countdown
    p_slave_load_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (slave != $past(slave)) |-> $past(state_q == SH_XFER && xcnt_q == '0));

    // Early write is dropped and flagged
    p_busy_drop_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_en && busy) |=> (collision && $stable(master)));

    // Accepted write lands in master
    p_master_load_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_en && !busy) |=> (master == $past(wr_data)));

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] count,
    output logic         irq,
    output logic         ovf
);

    logic hit;
    logic top;

    assign hit = (count == cmp);
    assign top = (count == {W{1'b1}});

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            count <= '0;
            irq   <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            irq <= 1'b0;
            ovf <= 1'b0;
            if (tick) begin
                if (hit) begin
                    count <= '0;
                    irq   <= 1'b1;
                end else begin
                    count <= count + W'(1);
                    ovf   <= top;
                end
            end
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
        !tick |=> $stable(count));

    p_irq_zero_r3: assert property (@(posedge clk) disable iff (!arst_n)
        irq |-> (count == '0));

    p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!arst_n)
        ovf |-> (count == '0 && $past(count) == {W{1'b1}}));

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!arst_n)
        !(irq && ovf));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int unsigned W        = 16,
    parameter int unsigned XFER_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            wr_cmp,
    input  logic            clr_coll,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    master,
    output logic [ST_W-1:0] status,
    output logic            irq,
    output logic            ovf
);

    logic         arst_n;
    logic [W-1:0] slave;
    logic [W-1:0] count;
    logic         pending;
    logic         collision;

    // Channel enable acts as an asynchronous reset (R1)
    assign arst_n = rst_n & en;

    cmt_shadow #(.W(W), .XFER_CYC(XFER_CYC)) u_shadow (
        .clk       (clk),
        .arst_n    (arst_n),
        .wr_en     (wr_cmp),
        .wr_data   (wdata),
        .clr_coll  (clr_coll),
        .master    (master),
        .slave     (slave),
        .pending   (pending),
        .collision (collision)
    );

    cmt_counter #(.W(W)) u_counter (
        .clk    (clk),
        .arst_n (arst_n),
        .tick   (tick),
        .cmp    (slave),
        .count  (count),
        .irq    (irq),
        .ovf    (ovf)
    );

    always_comb begin
        status              = '0;
        status[ST_COLL_BIT] = collision;
        status[ST_PEND_BIT] = pending;
    end

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int unsigned N_CH     = 4,
    parameter int unsigned W        = 16,
    parameter int unsigned XFER_CYC = 4,
    localparam int unsigned CHW     = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int unsigned AW      = CHW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] ch_en,
    input  logic [N_CH-1:0] tick,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    output logic [N_CH-1:0] irq,
    output logic [N_CH-1:0] ovf
);

    logic [CHW-1:0]  ch_sel;
    logic            reg_sel;
    logic [W-1:0]    master_a [N_CH];
    logic [ST_W-1:0] stat_a   [N_CH];

    assign ch_sel  = bus_addr[AW-1:1];
    assign reg_sel = bus_addr[0];

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic sel;
        assign sel = (ch_sel == CHW'(i));

        cmt_channel #(.W(W), .XFER_CYC(XFER_CYC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[i]),
            .tick     (tick[i]),
            .wr_cmp   (bus_wr && sel && !reg_sel),
            .clr_coll (bus_wr && sel && reg_sel && bus_wdata[ST_COLL_BIT]),
            .wdata    (bus_wdata),
            .master   (master_a[i]),
            .status   (stat_a[i]),
            .irq      (irq[i]),
            .ovf      (ovf[i])
        );
    end

    // Read mux: compare returns master, status returns flags
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_sel == CHW'(i)) begin
                bus_rdata = reg_sel ? W'(stat_a[i]) : master_a[i];
            end
        end
    end

endmodule

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;

    localparam int N_CH = 4;
    localparam int W    = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N_CH-1:0] ch_en = '1;
    logic [N_CH-1:0] tick = '0;
    logic            bus_wr = 1'b0;
    logic [2:0]      bus_addr = '0;
    logic [W-1:0]    bus_wdata = '0;
    logic [W-1:0]    bus_rdata;
    logic [N_CH-1:0] irq;
    logic [N_CH-1:0] ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmt_timer #(.N_CH(N_CH), .W(W), .XFER_CYC(4)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .ovf       (ovf)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int ch, input bit sel, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = {2'(ch), sel};
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input int ch, input bit sel, output logic [W-1:0] d);
        bus_addr = {2'(ch), sel};
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        @(negedge clk);
        for (int c = 0; c < N_CH; c++) begin
            bus_read(c, 1'b0, d);
            chk("R1", "compare after reset", int'(d), 0);
            bus_read(c, 1'b1, d);
            chk("R1", "status after reset", int'(d), 0);
        end
        chk("R1", "irq/ovf after reset", int'({irq, ovf}), 0);
    endtask

    task automatic t_disable();
        logic [W-1:0] d;
        bus_write(1, 1'b0, 16'h0055);
        bus_read(1, 1'b0, d);
        chk("R4", "master readback", int'(d), 'h55);
        repeat (5) @(negedge clk);
        ch_en[1] = 1'b0;
        #1;
        bus_read(1, 1'b0, d);
        chk("R1", "disabled clears master", int'(d), 0);
        bus_write(1, 1'b0, 16'h1234);
        bus_read(1, 1'b0, d);
        chk("R1", "write while disabled ignored", int'(d), 0);
        bus_read(1, 1'b1, d);
        chk("R1", "status while disabled", int'(d), 0);
        ch_en[1] = 1'b1;
        @(negedge clk);
        bus_read(1, 1'b0, d);
        chk("R1", "master after re-enable", int'(d), 0);
    endtask

    // Old slave value (0) governs until the fourth edge after the write
    task automatic t_xfer();
        logic [W-1:0] d;
        int bad;
        bad = 0;
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = {2'd0, 1'b0};
        bus_wdata = 16'd3;
        tick[0]   = 1'b1;
        for (int k = 0; k <= 8; k++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            if (irq[0] != ((k <= 4) || (k == 8))) begin
                bad++;
                $display("FAIL R5 irq after edge %0d: actual=%0b expected=%0b",
                         k, irq[0], ((k <= 4) || (k == 8)));
            end
            if (k == 3) begin
                bus_read(0, 1'b1, d);
                chk("R5", "pending before fourth edge", int'(d[1]), 1);
            end
            if (k == 4) begin
                bus_read(0, 1'b1, d);
                chk("R5", "pending cleared at fourth edge", int'(d[1]), 0);
            end
        end
        tick[0] = 1'b0;
        checks++;
        if (bad != 0) errors++;
    endtask

    // Tick pattern against a counter model built from R2/R3
    task automatic t_period();
        int cnt_m;
        int bad;
        bit exp_irq;
        bit tk;
        bus_write(1, 1'b0, 16'd9);
        repeat (6) @(negedge clk);
        cnt_m = 0;
        bad   = 0;
        exp_irq = 1'b0;
        for (int k = 0; k < 90; k++) begin
            tk = (k < 40) ? 1'b1 : ((k % 3) != 0);
            tick[1] = tk;
            @(negedge clk);
            exp_irq = 1'b0;
            if (tk) begin
                if (cnt_m == 9) begin
                    cnt_m = 0;
                    exp_irq = 1'b1;
                end else begin
                    cnt_m++;
                end
            end
            if (irq[1] != exp_irq) begin
                bad++;
                $display("FAIL R2 R3 irq at step %0d: actual=%0b expected=%0b", k, irq[1], exp_irq);
            end
            if (k == 9) chk("R3", "first irq after compare+1 ticks", int'(irq[1]), 1);
        end
        tick[1] = 1'b0;
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic t_collision();
        logic [W-1:0] d;
        bus_write(2, 1'b0, 16'h0040);
        @(negedge clk);
        bus_write(2, 1'b0, 16'h0099);
        bus_read(2, 1'b0, d);
        chk("R6", "early write dropped", int'(d), 'h40);
        bus_read(2, 1'b1, d);
        chk("R6", "collision set", int'(d[0]), 1);
        repeat (4) @(negedge clk);
        bus_write(2, 1'b1, 16'h0001);
        bus_read(2, 1'b1, d);
        chk("R6", "collision cleared", int'(d[0]), 0);
        bus_write(2, 1'b0, 16'h0021);
        repeat (2) @(negedge clk);
        bus_write(2, 1'b0, 16'h0022);
        bus_read(2, 1'b0, d);
        chk("R6", "write four clocks apart accepted", int'(d), 'h22);
        bus_read(2, 1'b1, d);
        chk("R6", "no collision at four clocks", int'(d[0]), 0);
        repeat (6) @(negedge clk);
    endtask

    // Ch2 lowered below count wraps (R8, R7); ch3 matches at FFFFH (R7, R9)
    task automatic t_wrap();
        int ovf2_k, irq2_k, irq3_k, ovf2_n, irq2_n, irq3_n, ovf3_n;
        bus_write(2, 1'b0, 16'd200);
        bus_write(3, 1'b0, 16'hFFFF);
        repeat (6) @(negedge clk);
        ovf2_k = -1; irq2_k = -1; irq3_k = -1;
        ovf2_n = 0;  irq2_n = 0;  irq3_n = 0; ovf3_n = 0;
        tick[2] = 1'b1;
        tick[3] = 1'b1;
        for (int k = 1; k <= 65600; k++) begin
            @(negedge clk);
            if (ovf[2]) begin ovf2_n++; ovf2_k = k; end
            if (irq[2]) begin irq2_n++; irq2_k = k; end
            if (irq[3]) begin irq3_n++; irq3_k = k; end
            if (ovf[3]) ovf3_n++;
            if (k == 100) begin
                bus_wr    = 1'b1;
                bus_addr  = {2'd2, 1'b0};
                bus_wdata = 16'd50;
            end
            if (k == 101) bus_wr = 1'b0;
        end
        tick[2] = 1'b0;
        tick[3] = 1'b0;
        chk("R7", "ch2 wrap edge", ovf2_k, 65536);
        chk("R7", "ch2 single overflow", ovf2_n, 1);
        chk("R8", "ch2 match only after wrap", irq2_k, 65587);
        chk("R8", "ch2 single match", irq2_n, 1);
        chk("R7", "ch3 match at FFFFH", irq3_k, 65536);
        chk("R9", "ch3 irq count independent of ch2", irq3_n, 1);
        chk("R7", "ch3 no overflow on match", ovf3_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disable();
        t_xfer();
        t_period();
        t_collision();
        t_wrap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule